// File: doc/BRIEF.md
# 16-bit Execute Unit with Overflow Register

This block is the arithmetic and test stage of a small 16-bit processor. It handles the two-operand instruction format. Each accepted instruction brings a 4-bit opcode, two operand values and a destination code. The block returns a 16-bit result, a write enable for that result and a conditional-skip request for the instruction-skip logic downstream. It also keeps a 16-bit overflow register. For some opcodes that register takes the upper half of a 32-bit intermediate result. For the others it keeps its value. Operand fetch, memory access and the extended instruction format all stay outside this block.

Instructions enter through a valid/ready stream. A transfer takes place on a rising edge where `in_valid` and `in_ready` are both high. The result leaves through a second valid/ready stream and is registered one stage after acceptance. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An upstream source therefore stalls exactly when a result is waiting that nobody has taken. While `out_ready` is low, the pending result and its flags stay unchanged. The overflow register is updated on the same edge that accepts the instruction, so while a result is presented, `ovf` shows the value that instruction left behind.

Top module: `alu16_exec`

## Requirements
- R1: A result is presented with `out_valid` high on the edge after acceptance. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready` holds, `out_res`, `out_wr` and `out_skip` keep their values.
- R2: Opcode 1 (move) returns b. Opcode 2 returns a+b, 3 returns a−b, 4 returns a·b, each taken as the low 16 bits. Opcodes 9, 10 and 11 return a AND b, a OR b and a XOR b.
- R3: Opcodes 2, 3, 4, 5 (divide), 7 (shift left) and 8 (shift right) compute a 32-bit intermediate from zero-extended operands and load its upper 16 bits into `ovf`. A subtraction with a<b gives `ovf` = 0xFFFF. Divide and shift right give `ovf` = 0.
- R4: Opcodes 1, 6 (remainder), 9, 10 and 11 and the four test opcodes leave `ovf` unchanged.
- R5: Divide and remainder with b = 0 return 0. Divide by zero also loads `ovf` with 0.
- R6: A left shift by 16 to 31 returns 0 and gives `ovf` = a shifted left by (b−16). A left or right shift by 32 or more returns 0 and gives `ovf` = 0.
- R7: The test opcodes set `out_skip` when their condition fails. Opcode 12 skips when a≠b, 13 when a=b, 14 when a≤b (unsigned), and 15 when (a AND b) = 0. All other opcodes give `out_skip` = 0.
- R8: Test opcodes always give `out_wr` = 0. Opcodes 1 to 11 give `out_wr` = 1 only when the destination code is below 0x1F. A destination of 0x1F or above discards the result, but `ovf` is still updated.
- R9: After reset, `out_valid` = 0, `ovf` = 0 and `in_ready` = 1.
- R10: Opcode 0, which belongs to the extended format, yields a result with `out_wr` = 0 and `out_skip` = 0 and leaves `ovf` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_op | input | 4 | Opcode |
| in_a | input | 16 | First operand value |
| in_b | input | 16 | Second operand value |
| in_dst | input | 6 | Destination code of the first operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 16 | Result value |
| out_wr | output | 1 | Result should be written to the destination |
| out_skip | output | 1 | Request to skip the next instruction |
| ovf | output | 16 | Overflow register |

## Verification
Every result, including its write enable, skip flag and the matching overflow value, becomes visible on the rising edge that accepts the instruction. It then stays on the outputs until the edge where `out_ready` is high. The driver records each expected item when its handshake is certain. The monitor compares the head of the queue only on falling edges where `out_valid` and `out_ready` are both high. Checks therefore follow the design's own acceptance order however the bench toggles back-pressure. A separate falling-edge check compares each stalled result against the previous cycle to confirm that it does not change.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_EXT  = 4'h0,
    OP_MOVE = 4'h1,
    OP_ADD  = 4'h2,
    OP_SUB  = 4'h3,
    OP_MUL  = 4'h4,
    OP_DIV  = 4'h5,
    OP_REM  = 4'h6,
    OP_LSL  = 4'h7,
    OP_LSR  = 4'h8,
    OP_AND  = 4'h9,
    OP_OR   = 4'hA,
    OP_XOR  = 4'hB,
    OP_TEQ  = 4'hC,
    OP_TNE  = 4'hD,
    OP_TGT  = 4'hE,
    OP_TBIT = 4'hF
  } op_e;

  function automatic logic is_test(op_e op);
    return op inside {OP_TEQ, OP_TNE, OP_TGT, OP_TBIT};
  endfunction

  function automatic logic produces_value(op_e op);
    return (op != OP_EXT) && !is_test(op);
  endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic [DW-1:0] hi,
  output logic          hi_en
);
  localparam int W2 = 2 * DW;

  logic [W2-1:0] wa, wb, wide;

  assign wa = {{DW{1'b0}}, a};
  assign wb = {{DW{1'b0}}, b};

  always_comb begin
    wide  = '0;
    hi_en = 1'b0;
    unique case (op)
      OP_MOVE: wide = wb;
      OP_ADD:  begin wide = wa + wb; hi_en = 1'b1; end
      OP_SUB:  begin wide = wa - wb; hi_en = 1'b1; end
      OP_MUL:  begin wide = wa * wb; hi_en = 1'b1; end
      OP_DIV:  begin wide = (b == '0) ? '0 : (wa / wb); hi_en = 1'b1; end
      OP_REM:  wide = (b == '0) ? '0 : (wa % wb);
      OP_LSL:  begin wide = (wb >= W2) ? '0 : (wa << b); hi_en = 1'b1; end
      OP_LSR:  begin wide = (wb >= W2) ? '0 : (wa >> b); hi_en = 1'b1; end
      OP_AND:  wide = wa & wb;
      OP_OR:   wide = wa | wb;
      OP_XOR:  wide = wa ^ wb;
      default: wide = '0;
    endcase
  end

  assign res = wide[DW-1:0];
  assign hi  = wide[W2-1:DW];

endmodule

// File: rtl/alu16_cond.sv
module alu16_cond
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          skip
);
  always_comb begin
    unique case (op)
      OP_TEQ:  skip = (a != b);
      OP_TNE:  skip = (a == b);
      OP_TGT:  skip = (a <= b);
      OP_TBIT: skip = ((a & b) == '0);
      default: skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu16_exec.sv
module alu16_exec
  import alu16_pkg::*;
#(
  parameter int DW       = 16,
  parameter int DSTW     = 6,
  parameter int LIT_BASE = 'h1F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_op,
  input  logic [DW-1:0]   in_a,
  input  logic [DW-1:0]   in_b,
  input  logic [DSTW-1:0] in_dst,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_res,
  output logic            out_wr,
  output logic            out_skip,
  output logic [DW-1:0]   ovf
);
  localparam logic [DSTW-1:0] LIT_CODE = DSTW'(LIT_BASE);

  op_e           op;
  logic          take;
  logic [DW-1:0] c_res, c_hi;
  logic          c_hi_en, c_skip, c_wr;

  assign op       = op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign c_wr     = produces_value(op) && (in_dst < LIT_CODE);

  alu16_arith #(.DW(DW)) arith_i (
    .op(op), .a(in_a), .b(in_b), .res(c_res), .hi(c_hi), .hi_en(c_hi_en)
  );

  alu16_cond #(.DW(DW)) cond_i (
    .op(op), .a(in_a), .b(in_b), .skip(c_skip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_wr    <= 1'b0;
      out_skip  <= 1'b0;
      ovf       <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_res   <= c_res;
      out_wr    <= c_wr;
      out_skip  <= c_skip;
      if (c_hi_en) ovf <= c_hi;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/alu16_exec_chk.sv
module alu16_exec_chk #(
  parameter int DW   = 16,
  parameter int DSTW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [3:0]      in_op,
  input logic [DW-1:0]   in_a,
  input logic [DW-1:0]   in_b,
  input logic [DSTW-1:0] in_dst,
  input logic            out_valid,
  input logic            out_ready,
  input logic [DW-1:0]   out_res,
  input logic            out_wr,
  input logic            out_skip,
  input logic [DW-1:0]   ovf
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_wr) && $stable(out_skip)));

  // R3
  borrow_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'h3 && in_a < in_b) |=> (ovf == '1));

  // R4
  keep_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == 4'h1 || in_op == 4'h6 || in_op >= 4'h9)) |=> $stable(ovf));

  // R5
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == 4'h5 || in_op == 4'h6) && in_b == '0) |=> (out_res == '0));

  // R7
  skip_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op < 4'hC) |=> !out_skip);

  // R8
  test_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op >= 4'hC) |=> !out_wr);

  // R8
  lit_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_dst >= DSTW'('h1F)) |=> !out_wr);

  // R10
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'h0) |=> (!out_wr && !out_skip && $stable(ovf)));

endmodule

bind alu16_exec alu16_exec_chk #(.DW(DW), .DSTW(DSTW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_dst(in_dst),
  .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
  .out_wr(out_wr), .out_skip(out_skip), .ovf(ovf)
);

// File: tb/alu16_exec_tb_top.sv
`timescale 1ns/1ps
module alu16_exec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [15:0] in_a = '0, in_b = '0;
  logic [5:0]  in_dst = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_res;
  logic        out_wr, out_skip;
  logic [15:0] ovf;

  int checks = 0;
  int errors = 0;
  bit bp_on = 1'b0;

  typedef struct {
    logic [15:0] res;
    logic        wr;
    logic        skip;
    logic [15:0] ovf;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] m_ovf = '0;

  always #4 clk = ~clk;

  alu16_exec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_dst(in_dst),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_wr(out_wr), .out_skip(out_skip), .ovf(ovf)
  );

  function automatic exp_t model(input logic [3:0] op, input logic [15:0] a,
                                 input logic [15:0] b, input logic [5:0] dst,
                                 input string tag);
    exp_t e;
    logic [31:0] t;
    logic        upd;
    t = 32'd0;
    upd = 1'b0;
    e.skip = 1'b0;
    case (op)
      4'h1: t = {16'd0, b};
      4'h2: begin t = {16'd0, a} + {16'd0, b}; upd = 1; end
      4'h3: begin t = {16'd0, a} - {16'd0, b}; upd = 1; end
      4'h4: begin t = {16'd0, a} * {16'd0, b}; upd = 1; end
      4'h5: begin t = (b == 0) ? 32'd0 : {16'd0, a / b}; upd = 1; end
      4'h6: t = (b == 0) ? 32'd0 : {16'd0, a % b};
      4'h7: begin t = (b >= 32) ? 32'd0 : ({16'd0, a} << b[4:0]); upd = 1; end
      4'h8: begin t = (b >= 16) ? 32'd0 : {16'd0, a >> b[3:0]}; upd = 1; end
      4'h9: t = {16'd0, a & b};
      4'hA: t = {16'd0, a | b};
      4'hB: t = {16'd0, a ^ b};
      4'hC: e.skip = !(a == b);
      4'hD: e.skip = (a == b);
      4'hE: e.skip = !(a > b);
      4'hF: e.skip = ((a & b) == 16'd0);
      default: ;
    endcase
    if (upd) m_ovf = t[31:16];
    e.res = t[15:0];
    e.wr  = (op >= 4'h1 && op <= 4'hB) && (dst < 6'h1F);
    e.ovf = m_ovf;
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [3:0] op, input logic [15:0] a,
                      input logic [15:0] b, input logic [5:0] dst, input string tag);
    @(negedge clk);
    #1;
    in_op = op; in_a = a; in_b = b; in_dst = dst; in_valid = 1'b1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(model(op, a, b, dst, tag));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor with back-pressure
  logic        prev_stall = 1'b0;
  logic [15:0] prev_res;
  logic        prev_wr, prev_skip;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_res == prev_res && out_wr == prev_wr && out_skip == prev_skip,
              "R1", "stalled result moved", {out_res, 14'd0, out_wr, out_skip},
              {prev_res, 14'd0, prev_wr, prev_skip});
      out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
      prev_stall = out_valid && !out_ready;
      prev_res = out_res; prev_wr = out_wr; prev_skip = out_skip;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1", "unexpected result", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_res == e.res, e.tag, "res", {16'd0, out_res}, {16'd0, e.res});
          check(out_wr == e.wr && out_skip == e.skip, e.tag, "wr/skip",
                {30'd0, out_wr, out_skip}, {30'd0, e.wr, e.skip});
          check(ovf == e.ovf, e.tag, "ovf", {16'd0, ovf}, {16'd0, e.ovf});
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check(!out_valid && ovf == 16'd0 && in_ready, "R9", "reset state",
          {15'd0, out_valid, ovf}, 32'd0);
    rst_n = 1'b1;

    send(4'h2, 16'hFFFF, 16'h0001, 6'h00, "R3");
    // R1 result present one edge after acceptance
    check(out_valid, "R1", "latency", {31'd0, out_valid}, 32'd1);
    send(4'h1, 16'h0000, 16'hBEEF, 6'h01, "R4");
    send(4'h3, 16'h0001, 16'h0002, 6'h02, "R3");
    send(4'h9, 16'hF0F0, 16'h3C3C, 6'h03, "R4");
    send(4'hA, 16'hF0F0, 16'h3C3C, 6'h04, "R2");
    send(4'hB, 16'hF0F0, 16'h3C3C, 6'h05, "R2");
    send(4'h4, 16'hFFFF, 16'hFFFF, 6'h06, "R3");
    send(4'h6, 16'd7, 16'd0, 6'h07, "R5");
    send(4'h5, 16'd7, 16'd0, 6'h07, "R5");
    send(4'h5, 16'd100, 16'd7, 6'h07, "R3");
    send(4'h6, 16'd100, 16'd7, 6'h07, "R4");
    send(4'h7, 16'h1234, 16'd20, 6'h00, "R6");
    send(4'h7, 16'h1234, 16'd40, 6'h00, "R6");
    send(4'h7, 16'h8001, 16'd1, 6'h00, "R3");
    send(4'h8, 16'h8000, 16'd100, 6'h00, "R6");
    send(4'h8, 16'h8000, 16'd15, 6'h00, "R3");
    send(4'hC, 16'd5, 16'd5, 6'h00, "R7");
    send(4'hC, 16'd5, 16'd6, 6'h00, "R7");
    send(4'hD, 16'd5, 16'd5, 6'h00, "R7");
    send(4'hE, 16'd5, 16'd5, 6'h00, "R7");
    send(4'hE, 16'd6, 16'd5, 6'h00, "R7");
    send(4'hF, 16'h00F0, 16'h0F00, 6'h00, "R7");
    send(4'hF, 16'h00F0, 16'h0010, 6'h00, "R8");
    send(4'h2, 16'hFFFF, 16'h0003, 6'h1F, "R8");
    send(4'h2, 16'h0001, 16'h0003, 6'h3F, "R8");
    send(4'h1, 16'h0001, 16'h0003, 6'h1E, "R8");
    send(4'h0, 16'h0001, 16'h0003, 6'h00, "R10");

    bp_on = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] b;
      b = $urandom;
      if (i % 5 == 0) b = 16'($urandom % 40);
      send(4'($urandom), 16'($urandom), b, 6'($urandom), "R2");
    end
    bp_on = 1'b0;

    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule